// File: doc/BRIEF.md
# Display Power Sequencer

This block orders the power transitions of a display interface so that a panel never receives drive without valid timing behind it. One software-owned request bit asks for power. When that bit rises, the sequencer starts the timing core at once. It then waits a programmable number of end-of-frame pulses before it raises the panel enable. When the bit falls, the panel enable drops at once. The timing core then keeps running for the same number of frames before it stops.

The guard length is sampled when each transition begins, so the interval in progress is fixed. A busy flag stays high for as long as the core runs, including the whole power-down interval. A power-on request made during power-down waits until busy clears.

The sequencer also registers the DMA enable for the frame-fetch engine. It will not drop that enable while the core is still busy. It reports DMA activity as a status bit.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset, core_en_o, panel_en_o, busy_o, dma_en_o and dma_busy_o are all 0.
- R2: With busy_o low, pwr_req_i sampled high raises core_en_o and busy_o on the next clock, while panel_en_o stays 0.
- R3: During power-up, panel_en_o rises on the clock that samples the Nth frame_end_i pulse, where N is guard_i as sampled at the start of power-up. It is not raised before that pulse.
- R4: A guard value of 0 acts as 1: panel_en_o rises on the clock that samples the first frame_end_i pulse.
- R5: With panel_en_o high, pwr_req_i sampled low clears panel_en_o on the next clock, while core_en_o and busy_o stay 1.
- R6: During power-down, core_en_o and busy_o fall on the clock that samples the Nth frame_end_i pulse, where N is the guard value sampled at the start of power-down (0 acts as 1).
- R7: A power-on request during power-down is held. busy_o falls as in R6, stays low for one cycle, and core_en_o rises again on the following clock if pwr_req_i is still high.
- R8: A change of guard_i after a transition has started has no effect on the interval in progress.
- R9: panel_en_o is never 1 while core_en_o is 0.
- R10: dma_en_o follows dma_en_req_i one clock later, except that a falling request is held off while busy_o is high. It takes effect on the clock after busy_o is seen low.
- R11: dma_busy_o is 1 whenever dma_en_o is 1 or dma_active_i is 1, and 0 otherwise, with no added delay.
- R12: frame_end_i pulses have no effect while the sequencer is fully off or fully on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_req_i | input | 1 | Software power request |
| guard_i | input | GUARD_W | Guard length in frames |
| frame_end_i | input | 1 | One-cycle end-of-frame pulse from the timing core |
| dma_en_req_i | input | 1 | Software DMA enable request |
| dma_active_i | input | 1 | Activity flag from the DMA engine |
| core_en_o | output | 1 | Enable for the timing core |
| panel_en_o | output | 1 | Panel power/enable |
| busy_o | output | 1 | Core still running |
| dma_en_o | output | 1 | Enable to the DMA engine |
| dma_busy_o | output | 1 | DMA busy status |

## Verification
A state register that is wrong shows at the ports one clock later. It appears as panel_en_o high with the core stopped, or as busy_o clear while the core still needs frames. A frame counter that miscounts or reloads moves the rising edge of panel_en_o, or the falling edge of busy_o, by whole frame pulses. The bench therefore checks these outputs after every pulse, not only at the end of each interval. A fault in the DMA gate shows as dma_en_o dropping in the same cycle in which its request falls while busy is still high.

// File: rtl/dps_pkg.sv
package dps_pkg;
   typedef enum logic [1:0] {
      PS_OFF  = 2'd0,
      PS_WARM = 2'd1,
      PS_ON   = 2'd2,
      PS_COOL = 2'd3
   } dps_state_e;
endpackage

// File: rtl/dps_frame_guard.sv
module dps_frame_guard #(
   parameter int GUARD_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               tick,
   input  logic [GUARD_W-1:0] target,
   output logic               reached
);
   localparam int CW = GUARD_W + 1;

   initial begin
      if (GUARD_W < 1 || GUARD_W > 16)
         $error("dps_frame_guard: GUARD_W out of range");
   end

   logic [GUARD_W-1:0] cnt_q;
   logic [GUARD_W-1:0] tgt_q;
   logic [GUARD_W-1:0] tgt_eff;
   logic [CW-1:0]      cnt_inc;

   // a zero guard still waits for one frame boundary
   assign tgt_eff = (tgt_q == '0) ? GUARD_W'(1) : tgt_q;
   assign cnt_inc = {1'b0, cnt_q} + CW'(1);
   assign reached = tick && !restart && (cnt_inc >= {1'b0, tgt_eff});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tgt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
         tgt_q <= target;
      end else if (tick && !reached) begin
         cnt_q <= cnt_inc[GUARD_W-1:0];
      end
   end

   // R3/R6: completion needs a frame pulse
   a_r3_reach_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      reached |-> tick);
endmodule

// File: rtl/dps_dma_gate.sv
module dps_dma_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic en_req,
   input  logic core_busy,
   input  logic engine_active,
   output logic en_o,
   output logic busy_o
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q <= 1'b0;
      else if (en_req)     en_q <= 1'b1;
      else if (!core_busy) en_q <= 1'b0;
   end

   assign en_o   = en_q;
   assign busy_o = en_q | engine_active;

   // R10: the enable is never withdrawn while the core is busy
   a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (core_busy && en_q) |=> en_q);
endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
   import dps_pkg::*;
#(
   parameter int GUARD_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_req_i,
   input  logic [GUARD_W-1:0] guard_i,
   input  logic               frame_end_i,
   input  logic               dma_en_req_i,
   input  logic               dma_active_i,
   output logic               core_en_o,
   output logic               panel_en_o,
   output logic               busy_o,
   output logic               dma_en_o,
   output logic               dma_busy_o
);
   dps_state_e state_q, state_d;
   logic       restart;
   logic       reached;

   always_comb begin
      state_d = state_q;
      restart = 1'b0;
      unique case (state_q)
         PS_OFF:  if (pwr_req_i) begin state_d = PS_WARM; restart = 1'b1; end
         PS_WARM: begin
            if (!pwr_req_i) begin state_d = PS_COOL; restart = 1'b1; end
            else if (reached) state_d = PS_ON;
         end
         PS_ON:   if (!pwr_req_i) begin state_d = PS_COOL; restart = 1'b1; end
         PS_COOL: if (reached) state_d = PS_OFF;
         default: state_d = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_OFF;
      else        state_q <= state_d;
   end

   dps_frame_guard #(.GUARD_W(GUARD_W)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (frame_end_i && (state_q == PS_WARM || state_q == PS_COOL)),
      .target  (guard_i),
      .reached (reached)
   );

   assign core_en_o  = (state_q != PS_OFF);
   assign busy_o     = (state_q != PS_OFF);
   assign panel_en_o = (state_q == PS_ON);

   dps_dma_gate u_dma (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_req        (dma_en_req_i),
      .core_busy     (busy_o),
      .engine_active (dma_active_i),
      .en_o          (dma_en_o),
      .busy_o        (dma_busy_o)
   );

   a_r9_panel_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
      panel_en_o |-> core_en_o);
   a_r2_start_core: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && pwr_req_i) |=> (core_en_o && !panel_en_o));
   a_r5_panel_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (panel_en_o && !pwr_req_i) |=> (!panel_en_o && busy_o));
   a_r3_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(panel_en_o) |-> $past(frame_end_i));
   a_r6_idle_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ($past(frame_end_i) && !panel_en_o));
endmodule

// File: tb/disp_pwr_seq_bench.sv
module disp_pwr_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_req_i = 1'b0;
   logic [6:0] guard_i = '0;
   logic       frame_end_i = 1'b0;
   logic       dma_en_req_i = 1'b0;
   logic       dma_active_i = 1'b0;
   logic       core_en_o, panel_en_o, busy_o, dma_en_o, dma_busy_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5ns clk = ~clk;

   disp_pwr_seq #(.GUARD_W(7)) u_disp_pwr_seq (
      .clk(clk), .rst_n(rst_n), .pwr_req_i(pwr_req_i), .guard_i(guard_i),
      .frame_end_i(frame_end_i), .dma_en_req_i(dma_en_req_i),
      .dma_active_i(dma_active_i), .core_en_o(core_en_o),
      .panel_en_o(panel_en_o), .busy_o(busy_o), .dma_en_o(dma_en_o),
      .dma_busy_o(dma_busy_o));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic frame();
      frame_end_i = 1'b1;
      tick();
      frame_end_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 core", core_en_o, 0);
      chk("R1 panel", panel_en_o, 0);
      chk("R1 busy", busy_o, 0);
      chk("R1 dma_en", dma_en_o, 0);
      chk("R1 dma_busy", dma_busy_o, 0);
      frame(); frame();
      chk("R12 off ignores frames", busy_o, 0);
   endtask

   task automatic t_power_up_guard3();
      guard_i = 7'd3; pwr_req_i = 1'b1;
      tick();
      chk("R2 core", core_en_o, 1);
      chk("R2 busy", busy_o, 1);
      chk("R2 panel", panel_en_o, 0);
      frame();
      chk("R3 after 1", panel_en_o, 0);
      guard_i = 7'd1; // R8: must not shorten the interval
      frame();
      chk("R8 after 2", panel_en_o, 0);
      tick(); tick();
      chk("R3 idle gap", panel_en_o, 0);
      frame();
      chk("R3 after 3", panel_en_o, 1);
      frame(); frame();
      chk("R12 on ignores frames", panel_en_o, 1);
   endtask

   task automatic t_power_down_guard2();
      guard_i = 7'd2; pwr_req_i = 1'b0;
      tick();
      chk("R5 panel", panel_en_o, 0);
      chk("R5 core", core_en_o, 1);
      chk("R5 busy", busy_o, 1);
      guard_i = 7'd9; // R8
      frame();
      chk("R6 after 1", busy_o, 1);
      frame();
      chk("R6 busy", busy_o, 0);
      chk("R6 core", core_en_o, 0);
   endtask

   task automatic t_zero_guard_and_held_request();
      guard_i = 7'd0; pwr_req_i = 1'b1;
      tick();
      chk("R4 core", core_en_o, 1);
      frame();
      chk("R4 panel after first frame", panel_en_o, 1);
      guard_i = 7'd1; pwr_req_i = 1'b0;
      tick();
      chk("R5 panel", panel_en_o, 0);
      pwr_req_i = 1'b1;
      tick(); tick();
      chk("R7 held busy", busy_o, 1);
      chk("R7 held panel", panel_en_o, 0);
      frame();
      chk("R7 off gap", busy_o, 0);
      tick();
      chk("R7 restart", core_en_o, 1);
      chk("R7 restart panel", panel_en_o, 0);
   endtask

   task automatic t_dma();
      dma_en_req_i = 1'b1;
      tick();
      chk("R10 follow", dma_en_o, 1);
      chk("R11 busy by en", dma_busy_o, 1);
      dma_en_req_i = 1'b0;
      tick();
      chk("R10 hold while busy", dma_en_o, 1);
      guard_i = 7'd1; pwr_req_i = 1'b0;
      tick();
      chk("R10 hold in cool", dma_en_o, 1);
      frame();
      chk("R6 off", busy_o, 0);
      chk("R10 same edge", dma_en_o, 1);
      tick();
      chk("R10 release", dma_en_o, 0);
      chk("R11 idle", dma_busy_o, 0);
      #1ns dma_active_i = 1'b1;
      #1ns chk("R11 engine", dma_busy_o, 1);
      dma_active_i = 1'b0;
      #1ns chk("R11 engine off", dma_busy_o, 0);
   endtask

   initial begin
      #(200000 * 10ns);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_power_up_guard3();
      t_power_down_guard2();
      t_zero_guard_and_held_request();
      t_dma();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule